// File: doc/BRIEF.md
# Reservation Station Array with Broadcast Wakeup

This block is a pool of reservation stations that serves one class of functional unit, such as an adder or a multiplier. The issue stage hands it an operation. Each source operand arrives either as a finished value or as the tag of the station that will produce it. The block keeps each operation until both operands hold values, then dispatches it to its functional unit.

Missing operands are filled by snooping a shared result bus. Every broadcast carries a producer tag and a value. Each waiting slot compares the broadcast tag against the tag it holds and captures the value when the two match. The register file is not involved in this path.

Every station is known by a nonzero tag equal to `TAG_BASE` plus its index. The issue logic reads the tag of the next free station from `issue_tag_o` and uses it to rename the destination register. When several stations are ready in the same cycle, the one allocated earliest is dispatched. At most one operation leaves per cycle, and it leaves under a valid/ready handshake.

Top module: `rs_array`

## Requirements
- R1: After reset every station is free: `full_o` is 0, `disp_valid_o` is 0 and `issue_tag_o` equals `TAG_BASE`.
- R2: While `full_o` is 0, `issue_tag_o` shows `TAG_BASE + i`, where i is the lowest-index free station. An issue with `issue_valid_i` high writes the operation into that station.
- R3: An operand tag of 0 means the operand value is valid. When a result broadcast's tag equals a nonzero operand tag held by a busy station, the station stores the broadcast value and sets that operand tag to 0. Both operands of one station can wake on the same broadcast.
- R4: If an issue carries a nonzero operand tag and a broadcast of that same tag occurs in the same cycle, the new station stores the broadcast value with tag 0.
- R5: `full_o` is 1 exactly when every station is busy. An issue made while `full_o` is 1 is dropped and changes no station.
- R6: `disp_valid_o` is 1 when at least one busy station has both operand tags equal to 0. The dispatch port then carries that station's opcode, both operand values, its immediate and its station tag.
- R7: When several stations are ready together, the one issued earliest is dispatched.
- R8: A dispatch takes place only in a cycle where both `disp_valid_o` and `disp_ready_i` are 1. That station is freed on the same clock edge and can take a new issue in the next cycle. An offered station stays valid while `disp_ready_i` is 0.
- R9: A broadcast whose tag matches no waiting operand has no effect, and this includes tags that belong to producers outside this array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | OP_W | Opcode |
| issue_vj_i | input | DATA_W | First operand value, used when issue_qj_i is 0 |
| issue_qj_i | input | TAG_W | First operand producer tag, 0 means the value is valid |
| issue_vk_i | input | DATA_W | Second operand value, used when issue_qk_i is 0 |
| issue_qk_i | input | TAG_W | Second operand producer tag, 0 means the value is valid |
| issue_imm_i | input | IMM_W | Immediate or address field |
| full_o | output | 1 | No free station, issue must stall |
| issue_tag_o | output | TAG_W | Tag of the station the next issue will occupy |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Tag of the broadcasting producer |
| cdb_value_i | input | DATA_W | Broadcast result value |
| disp_valid_o | output | 1 | A ready station is offered |
| disp_ready_i | input | 1 | Functional unit accepts the offered station |
| disp_op_o | output | OP_W | Dispatched opcode |
| disp_vj_o | output | DATA_W | Dispatched first operand |
| disp_vk_o | output | DATA_W | Dispatched second operand |
| disp_imm_o | output | IMM_W | Dispatched immediate |
| disp_tag_o | output | TAG_W | Tag of the dispatched station |

## Verification
The bench goes after issues that land in the same cycle as a broadcast of the tag they wait on. A design that skipped the bypass would park that station forever and never offer it. It also checks that a slot freed by a dispatch is reused on the very next issue. A design that released the slot late would raise `full_o` spuriously or report the wrong `issue_tag_o`. Long stretches of back-pressure on the dispatch port push the array to full while the bench keeps issuing. An array that accepted those issues would overwrite live operations. Those stretches also leave several stations ready at once, so an age tracker that lost order would dispatch a younger station ahead of an older one, and the bench would see the wrong tag and payload.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_ENTRIES  = 3;
  localparam int unsigned DEF_TAG_W    = 3;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_OP_W     = 4;
  localparam int unsigned DEF_IMM_W    = 16;
  localparam int unsigned DEF_TAG_BASE = 1;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     busy_i,
  input  logic             issue_valid_i,
  output logic             full_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [N-1:0]     alloc_o
);
  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign full_o = &busy_i;

  always_comb begin
    alloc_o = '0;
    if (issue_valid_i && !full_o) alloc_o[free_idx_o] = 1'b1;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic              disp_fire_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o,
  output logic [IMM_W-1:0]  imm_o
);
  logic              busy_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] vj_q, vk_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [IMM_W-1:0]  imm_q;

  // bypass for operands whose producer broadcasts in the issue cycle
  logic new_j_hit, new_k_hit, j_hit, k_hit;
  assign new_j_hit = cdb_valid_i && (qj_i != '0) && (cdb_tag_i == qj_i);
  assign new_k_hit = cdb_valid_i && (qk_i != '0) && (cdb_tag_i == qk_i);
  assign j_hit     = cdb_valid_i && busy_q && (qj_q != '0) && (cdb_tag_i == qj_q);
  assign k_hit     = cdb_valid_i && busy_q && (qk_q != '0) && (cdb_tag_i == qk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      vj_q   <= '0;
      vk_q   <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
      imm_q  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      imm_q  <= imm_i;
      vj_q   <= new_j_hit ? cdb_value_i : vj_i;
      qj_q   <= new_j_hit ? '0 : qj_i;
      vk_q   <= new_k_hit ? cdb_value_i : vk_i;
      qk_q   <= new_k_hit ? '0 : qk_i;
    end else begin
      if (disp_fire_i) busy_q <= 1'b0;
      if (j_hit) begin
        vj_q <= cdb_value_i;
        qj_q <= '0;
      end
      if (k_hit) begin
        vk_q <= cdb_value_i;
        qk_q <= '0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (qj_q == '0) && (qk_q == '0);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;
  assign imm_o   = imm_q;

  a_r8_free_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fire_i |=> !busy_q);
  a_r3_wake_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && j_hit) |=> (qj_q == '0) && (vj_q == $past(cdb_value_i)));
  a_r3_wake_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && k_hit) |=> (qk_q == '0) && (vk_q == $past(cdb_value_i)));
  a_r4_issue_bypass_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && new_j_hit) |=> ready_o || (qk_q != '0));
  a_r8_no_release_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fire_i |-> ready_o);
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] grant_o,
  output logic         valid_o
);
  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i != j) begin
            if (alloc_i[i])      older_q[i][j] <= 1'b0;
            else if (alloc_i[j]) older_q[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant_o[i] = ready_i[i];
      for (int j = 0; j < N; j++) begin
        if (i != j && ready_i[j] && !older_q[i][j]) grant_o[i] = 1'b0;
      end
    end
  end

  assign valid_o = |ready_i;

  a_r7_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r6_grant_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(grant_o) == 1);
  a_r7_single_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_i));
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_ENTRIES,
  parameter int unsigned TAG_W     = DEF_TAG_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned OP_W      = DEF_OP_W,
  parameter int unsigned IMM_W     = DEF_IMM_W,
  parameter int unsigned TAG_BASE  = DEF_TAG_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  input  logic [IMM_W-1:0]  issue_imm_i,
  output logic              full_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_vj_o,
  output logic [DATA_W-1:0] disp_vk_o,
  output logic [IMM_W-1:0]  disp_imm_o,
  output logic [TAG_W-1:0]  disp_tag_o
);
  localparam int unsigned IDX_W = idx_width(N_ENTRIES);

  initial begin
    a_tag_range: assert (TAG_BASE >= 1 && TAG_BASE + N_ENTRIES <= (1 << TAG_W));
  end

  logic [N_ENTRIES-1:0] busy, ready, alloc, grant, fire;
  logic [IDX_W-1:0]     free_idx, sel_idx;
  logic [OP_W-1:0]      e_op  [N_ENTRIES];
  logic [DATA_W-1:0]    e_vj  [N_ENTRIES];
  logic [DATA_W-1:0]    e_vk  [N_ENTRIES];
  logic [IMM_W-1:0]     e_imm [N_ENTRIES];
  logic                 disp_fire;

  rs_alloc #(.N(N_ENTRIES), .IDX_W(IDX_W)) i_alloc (
    .busy_i        (busy),
    .issue_valid_i (issue_valid_i),
    .full_o        (full_o),
    .free_idx_o    (free_idx),
    .alloc_o       (alloc)
  );

  assign issue_tag_o = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .IMM_W(IMM_W)) i_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[g]),
      .op_i        (issue_op_i),
      .vj_i        (issue_vj_i),
      .qj_i        (issue_qj_i),
      .vk_i        (issue_vk_i),
      .qk_i        (issue_qk_i),
      .imm_i       (issue_imm_i),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_value_i (cdb_value_i),
      .disp_fire_i (fire[g]),
      .busy_o      (busy[g]),
      .ready_o     (ready[g]),
      .op_o        (e_op[g]),
      .vj_o        (e_vj[g]),
      .vk_o        (e_vk[g]),
      .imm_o       (e_imm[g])
    );
  end

  rs_age_select #(.N(N_ENTRIES)) i_select (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc),
    .ready_i (ready),
    .grant_o (grant),
    .valid_o (disp_valid_o)
  );

  assign disp_fire = disp_valid_o && disp_ready_i;
  assign fire      = disp_fire ? grant : '0;

  always_comb begin
    sel_idx    = '0;
    disp_op_o  = '0;
    disp_vj_o  = '0;
    disp_vk_o  = '0;
    disp_imm_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (grant[i]) begin
        sel_idx    = IDX_W'(i);
        disp_op_o  = disp_op_o  | e_op[i];
        disp_vj_o  = disp_vj_o  | e_vj[i];
        disp_vk_o  = disp_vk_o  | e_vk[i];
        disp_imm_o = disp_imm_o | e_imm[i];
      end
    end
  end

  assign disp_tag_o = TAG_W'(TAG_BASE) + TAG_W'(sel_idx);

  a_r5_full_blocks_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $countones(busy) <= $past($countones(busy)));
  a_r6_tag_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> disp_tag_o != '0);
  a_r8_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && !disp_ready_i) |=> disp_valid_o);
  a_r2_issue_tag_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !full_o) |=> busy[$past(free_idx)]);
endmodule

// File: tb/test_rs_array.sv
`timescale 1ns/1ps
module test_rs_array;
  localparam int N = 3, TW = 3, DW = 16, OW = 4, IW = 16, TB = 1;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic issue_valid, cdb_valid, disp_ready;
  logic [OW-1:0] issue_op;
  logic [DW-1:0] issue_vj, issue_vk, cdb_value;
  logic [TW-1:0] issue_qj, issue_qk, cdb_tag;
  logic [IW-1:0] issue_imm;
  logic full, disp_valid;
  logic [TW-1:0] issue_tag, disp_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;
  logic [IW-1:0] disp_imm;

  always #10 clk = ~clk;

  rs_array #(.N_ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW), .IMM_W(IW), .TAG_BASE(TB)) i_rs_array (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_op_i(issue_op),
    .issue_vj_i(issue_vj), .issue_qj_i(issue_qj),
    .issue_vk_i(issue_vk), .issue_qk_i(issue_qk),
    .issue_imm_i(issue_imm), .full_o(full), .issue_tag_o(issue_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
    .disp_valid_o(disp_valid), .disp_ready_i(disp_ready),
    .disp_op_o(disp_op), .disp_vj_o(disp_vj), .disp_vk_o(disp_vk),
    .disp_imm_o(disp_imm), .disp_tag_o(disp_tag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit            m_busy [N];
  logic [OW-1:0] m_op   [N];
  logic [DW-1:0] m_vj   [N];
  logic [DW-1:0] m_vk   [N];
  logic [TW-1:0] m_qj   [N];
  logic [TW-1:0] m_qk   [N];
  logic [IW-1:0] m_imm  [N];
  int            m_seq  [N];
  int            seq_ctr = 0;

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return 0;
    return 1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int m_sel();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && m_qj[i] == 0 && m_qk[i] == 0)
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    return best;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int s = m_sel();
    chk("R5 full", full, m_full());
    if (!m_full()) chk("R2 issue_tag", issue_tag, m_free() + TB);
    chk("R6 disp_valid", disp_valid, s >= 0);
    if (s >= 0) begin
      chk("R7 disp_tag", disp_tag, s + TB);
      chk("R6 disp_op", disp_op, m_op[s]);
      chk("R3 R4 R9 disp_vj", disp_vj, m_vj[s]);
      chk("R3 R4 R9 disp_vk", disp_vk, m_vk[s]);
      chk("R6 disp_imm", disp_imm, m_imm[s]);
    end
  endtask

  // drive at negedge, advance model, check after posedge
  task automatic step(input int rdy_pct);
    int s;
    int f;
    @(negedge clk);
    s = m_sel();
    issue_valid = ($urandom_range(0, 99) < 60);
    issue_op    = OW'($urandom);
    issue_vj    = DW'($urandom);
    issue_vk    = DW'($urandom);
    issue_qj    = ($urandom_range(0, 2) == 0) ? '0 : TW'($urandom_range(1, 6));
    issue_qk    = ($urandom_range(0, 2) == 0) ? '0 : TW'($urandom_range(1, 6));
    issue_imm   = IW'($urandom);
    cdb_valid   = ($urandom_range(0, 1) == 1);
    cdb_tag     = TW'($urandom_range(1, 7));
    cdb_value   = DW'($urandom);
    disp_ready  = ($urandom_range(0, 99) < rdy_pct);
    f = m_free();
    if (s >= 0 && disp_ready) m_busy[s] = 0;
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && cdb_valid) begin
        if (m_qj[i] != 0 && m_qj[i] == cdb_tag) begin m_vj[i] = cdb_value; m_qj[i] = 0; end
        if (m_qk[i] != 0 && m_qk[i] == cdb_tag) begin m_vk[i] = cdb_value; m_qk[i] = 0; end
      end
    end
    if (issue_valid && f >= 0) begin
      m_busy[f] = 1;
      m_op[f]   = issue_op;
      m_imm[f]  = issue_imm;
      m_seq[f]  = seq_ctr++;
      if (issue_qj != 0 && cdb_valid && cdb_tag == issue_qj) begin m_vj[f] = cdb_value; m_qj[f] = 0; end
      else begin m_vj[f] = issue_vj; m_qj[f] = issue_qj; end
      if (issue_qk != 0 && cdb_valid && cdb_tag == issue_qk) begin m_vk[f] = cdb_value; m_qk[f] = 0; end
      else begin m_vk[f] = issue_vk; m_qk[f] = issue_qk; end
    end
    @(posedge clk);
    #1;
    compare();
  endtask

  initial begin
    issue_valid = 0; issue_op = '0; issue_vj = '0; issue_vk = '0;
    issue_qj = '0; issue_qk = '0; issue_imm = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_value = '0; disp_ready = 0;
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_op[i] = '0; m_vj[i] = '0; m_vk[i] = '0;
      m_qj[i] = '0; m_qk[i] = '0; m_imm[i] = '0; m_seq[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 full", full, 0);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 issue_tag", issue_tag, TB);
    // phases: heavy back-pressure, free flow, mixed
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 1500; c++) begin
        case (p)
          0: step(10);
          1: step(100);
          2: step(60);
          default: step(0);
        endcase
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < MAX_CYC) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, MAX_CYC);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule